// File: doc/BRIEF.md
# Serial Configuration Port with Frame Readback

This block is the device-side configuration port of a multi-channel converter. A host arms a write by pulsing the active-low strobe `cfg_rst_n` while `conv` is low. It then clocks a 12-bit word in on `cfg_sdi`, most significant bit first, taking one bit on each falling edge of `cfg_sclk`. The word takes effect only after the twelfth bit. A write that is cut short by a `conv` strobe, or restarted by a new strobe, leaves the stored word unchanged.

Once the word is stored, the port enters readback. On `dout` it presents a frame that shifts by one bit on each rising edge of `dclk`. Each half of the frame holds the stored word, a 4-bit revision code and a test-pattern field. The field is zero except for a fixed constant that sits right-aligned at its end. The format bit of the word chooses the field length and which constant is used. The half is sent twice. After that, `dout` passes on the bits taken in from `din`, so that several ports wired output to input form one chain.

A rising edge on `conv` leaves readback and returns to normal operation. In normal operation `dout` is held at 0. All pin inputs are resynchronised to `clk` and their edges are detected there.

Top module: `cfg_readback_port`

## Requirements
- R1: After `rst_n` is released, `cfg_word` equals the parameterised reset value (default 0) and `dout` is 0.
- R2: A write is armed only by a low-to-high transition of `cfg_rst_n` while `conv` is low. If `conv` is high at that transition, the strobe is ignored, and bits clocked afterwards do not change `cfg_word` or `dout`.
- R3: In an armed write, `cfg_sdi` is sampled on each falling edge of `cfg_sclk`, first bit into bit 11. After the twelfth bit, `cfg_word` holds exactly the word that was sent.
- R4: If `conv` rises after fewer than 12 bits, the write is abandoned and `cfg_word` keeps its previous value.
- R5: A new arming strobe during a write discards the bits taken so far. The next 12 bits form the stored word.
- R6: As soon as the word is stored, `dout` shows the first frame bit. Each rising `dclk` edge advances one bit. Each half-frame is: word bits 11 down to 0, then the revision code bits 3 down to 0, then the pattern field.
- R7: With bit 0 of the word at 1, the pattern field is 304 bits. It is 232 zeros followed by 72'h30F066012480F69055, MSB first. The half-frame is 320 bits and the whole frame is 640 bits.
- R8: With bit 0 of the word at 0, the pattern field is 240 bits. It is 184 zeros followed by 56'h30F066012480F6. The half-frame is 256 bits and the whole frame is 512 bits.
- R9: The second half-frame repeats the first one bit for bit.
- R10: With a frame length of L, the bit on `dout` after L+j rising `dclk` edges equals the `din` value present at rising edge j (counted from 0).
- R11: A rising edge on `conv` ends readback. From then on `dout` is 0 and `dclk` edges have no effect, while `cfg_word` is kept.
- R12: An arming strobe during readback aborts the frame at once (`dout` goes to 0) and starts a fresh write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cfg_rst_n | input | 1 | Active-low arming strobe; acts on its rising edge |
| conv | input | 1 | Conversion control; its rising edge ends configuration |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_sclk | input | 1 | Configuration bit clock; sampled on its falling edge |
| dclk | input | 1 | Readback shift clock; acts on its rising edge |
| din | input | 1 | Chain input from the upstream port |
| dout | output | 1 | Readback / chain output |
| cfg_word | output | 12 | Stored configuration word |

## Verification
The checker checks several things on every clock. The stored word changes only in the cycle after a twelfth-bit commit, and then to the value assembled by the receiver. The first frame bit matches the word's MSB right after a commit. The output falls to 0 right after a `conv` rising edge and right after an arming strobe. The bit counter never passes the word length. Frame content, field lengths for both formats, the repeated half, the chained forwarding offset and the handling of partial or restarted writes are only visible across long pin sequences, so the bench scenarios cover them.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2
   } cfgrb_state_e;

   // positions of the pins inside the synchroniser vector
   localparam int PIN_RSTB = 0;
   localparam int PIN_CONV = 1;
   localparam int PIN_SCLK = 2;
   localparam int PIN_DCLK = 3;
   localparam int PIN_SDI  = 4;
   localparam int PIN_DIN  = 5;
   localparam int PIN_CNT  = 6;
   localparam int CTL_CNT  = 4;

endpackage

// File: rtl/cfgrb_sync.sv
module cfgrb_sync #(
   parameter int               W      = 6,
   parameter int               STAGES = 2,
   parameter logic [W-1:0]     INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("cfgrb_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= INIT;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end

         assign q = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/cfgrb_word_rx.sv
module cfgrb_word_rx #(
   parameter int CFG_W = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          enable,
   input  logic                          sample,
   input  logic                          bit_in,
   output logic                          commit,
   output logic [CFG_W-1:0]              word_out,
   output logic [$clog2(CFG_W+1)-1:0]    bit_cnt
);

   localparam int CNT_W = $clog2(CFG_W + 1);

   logic [CFG_W-2:0] sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last;
   logic             take;

   generate
      if (CFG_W < 2) begin : g_bad
         $error("cfgrb_word_rx: CFG_W must be at least 2");
      end
   endgenerate

   assign last     = (cnt_q == CNT_W'(CFG_W - 1));
   assign take     = enable & sample;
   assign commit   = take & last;
   assign word_out = {sh_q, bit_in};
   assign bit_cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (take) begin
         sh_q  <= word_out[CFG_W-2:0];
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/cfgrb_frame_tx.sv
module cfgrb_frame_tx #(
   parameter int                CFG_W    = 12,
   parameter int                REV_W    = 4,
   parameter logic [REV_W-1:0]  REV_ID   = 4'h1,
   parameter int                FMT_BIT  = 0,
   parameter int                FIELD0_W = 240,
   parameter int                FIELD1_W = 304,
   parameter int                PAT0_W   = 56,
   parameter logic [PAT0_W-1:0] PAT0     = 56'h30F066012480F6,
   parameter int                PAT1_W   = 72,
   parameter logic [PAT1_W-1:0] PAT1     = 72'h30F066012480F69055,
   parameter int                COPIES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] word,
   input  logic             shift,
   input  logic             ser_in,
   output logic             ser_out
);

   localparam int HALF0  = CFG_W + REV_W + FIELD0_W;
   localparam int HALF1  = CFG_W + REV_W + FIELD1_W;
   localparam int LEN0   = COPIES * HALF0;
   localparam int LEN1   = COPIES * HALF1;
   localparam int MAXLEN = (LEN1 > LEN0) ? LEN1 : LEN0;
   localparam int TAP0   = MAXLEN - LEN0;
   localparam int TAP1   = MAXLEN - LEN1;
   localparam int IDX_W  = $clog2(MAXLEN);

   logic [HALF0-1:0]  half0;
   logic [HALF1-1:0]  half1;
   logic [MAXLEN-1:0] img0, img1;
   logic [MAXLEN-1:0] frame_q, frame_nxt;
   logic [IDX_W-1:0]  tap;
   logic              fmt_q;

   generate
      if (PAT0_W > FIELD0_W || PAT1_W > FIELD1_W) begin : g_bad_pat
         $error("cfgrb_frame_tx: pattern wider than its field");
      end
      if (COPIES < 1) begin : g_bad_copies
         $error("cfgrb_frame_tx: COPIES must be at least 1");
      end
   endgenerate

   // frame images for both formats, left-aligned in the shift register
   always_comb begin
      half0 = {word, REV_ID, FIELD0_W'(PAT0)};
      half1 = {word, REV_ID, FIELD1_W'(PAT1)};
      img0  = '0;
      img1  = '0;
      img0[MAXLEN-1 -: LEN0] = {COPIES{half0}};
      img1[MAXLEN-1 -: LEN1] = {COPIES{half1}};
   end

   // chain input enters just below the active part of the register
   always_comb begin
      tap       = fmt_q ? IDX_W'(TAP1) : IDX_W'(TAP0);
      frame_nxt = frame_q << 1;
      frame_nxt[tap] = ser_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         fmt_q   <= 1'b0;
      end else if (load) begin
         frame_q <= word[FMT_BIT] ? img1 : img0;
         fmt_q   <= word[FMT_BIT];
      end else if (shift) begin
         frame_q <= frame_nxt;
      end
   end

   assign ser_out = frame_q[MAXLEN-1];

endmodule

// File: rtl/cfg_readback_port.sv
module cfg_readback_port #(
   parameter int                CFG_W      = 12,
   parameter logic [CFG_W-1:0]  CFG_RESET  = '0,
   parameter int                REV_W      = 4,
   parameter logic [REV_W-1:0]  REV_ID     = 4'h1,
   parameter int                FMT_BIT    = 0,
   parameter int                FIELD0_W   = 240,
   parameter int                FIELD1_W   = 304,
   parameter int                PAT0_W     = 56,
   parameter logic [PAT0_W-1:0] PAT0       = 56'h30F066012480F6,
   parameter int                PAT1_W     = 72,
   parameter logic [PAT1_W-1:0] PAT1       = 72'h30F066012480F69055,
   parameter int                COPIES     = 2,
   parameter int                SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_rst_n,
   input  logic             conv,
   input  logic             cfg_sdi,
   input  logic             cfg_sclk,
   input  logic             dclk,
   input  logic             din,
   output logic             dout,
   output logic [CFG_W-1:0] cfg_word
);

   import cfgrb_pkg::*;

   localparam int CNT_W = $clog2(CFG_W + 1);
   localparam logic [PIN_CNT-1:0] SYNC_INIT = PIN_CNT'(1) << PIN_RSTB;

   generate
      if (FMT_BIT < 0 || FMT_BIT >= CFG_W) begin : g_bad_fmt
         $error("cfg_readback_port: FMT_BIT outside the word");
      end
   endgenerate

   logic [PIN_CNT-1:0] pins_raw, pins_s;
   logic [CTL_CNT-1:0] ctl_prev_q;
   logic               arm, conv_rise, sclk_fall, dclk_rise;
   cfgrb_state_e       state_q;
   logic               commit;
   logic [CFG_W-1:0]   new_word;
   logic [CNT_W-1:0]   bit_cnt;
   logic [CFG_W-1:0]   cfg_word_q;
   logic               rx_enable, tx_shift, tx_out;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_RSTB] = cfg_rst_n;
      pins_raw[PIN_CONV] = conv;
      pins_raw[PIN_SCLK] = cfg_sclk;
      pins_raw[PIN_DCLK] = dclk;
      pins_raw[PIN_SDI]  = cfg_sdi;
      pins_raw[PIN_DIN]  = din;
   end

   cfgrb_sync #(
      .W      (PIN_CNT),
      .STAGES (SYNC_STAGES),
      .INIT   (SYNC_INIT)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_prev_q <= SYNC_INIT[CTL_CNT-1:0];
      else        ctl_prev_q <= pins_s[CTL_CNT-1:0];
   end

   assign arm       =  pins_s[PIN_RSTB] & ~ctl_prev_q[PIN_RSTB] & ~pins_s[PIN_CONV];
   assign conv_rise =  pins_s[PIN_CONV] & ~ctl_prev_q[PIN_CONV];
   assign sclk_fall = ~pins_s[PIN_SCLK] &  ctl_prev_q[PIN_SCLK];
   assign dclk_rise =  pins_s[PIN_DCLK] & ~ctl_prev_q[PIN_DCLK];

   // mode sequencing: arming wins, then the conversion strobe, then commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         state_q <= ST_IDLE;
      else if (arm)       state_q <= ST_WRITE;
      else if (conv_rise) state_q <= ST_IDLE;
      else if (commit)    state_q <= ST_READ;
   end

   assign rx_enable = (state_q == ST_WRITE) & ~conv_rise & ~arm;

   cfgrb_word_rx #(
      .CFG_W (CFG_W)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (arm),
      .enable   (rx_enable),
      .sample   (sclk_fall),
      .bit_in   (pins_s[PIN_SDI]),
      .commit   (commit),
      .word_out (new_word),
      .bit_cnt  (bit_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_word_q <= CFG_RESET;
      else if (commit) cfg_word_q <= new_word;
   end

   assign tx_shift = (state_q == ST_READ) & dclk_rise & ~conv_rise & ~arm;

   cfgrb_frame_tx #(
      .CFG_W    (CFG_W),
      .REV_W    (REV_W),
      .REV_ID   (REV_ID),
      .FMT_BIT  (FMT_BIT),
      .FIELD0_W (FIELD0_W),
      .FIELD1_W (FIELD1_W),
      .PAT0_W   (PAT0_W),
      .PAT0     (PAT0),
      .PAT1_W   (PAT1_W),
      .PAT1     (PAT1),
      .COPIES   (COPIES)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (commit),
      .word    (new_word),
      .shift   (tx_shift),
      .ser_in  (pins_s[PIN_DIN]),
      .ser_out (tx_out)
   );

   assign dout     = (state_q == ST_READ) & tx_out;
   assign cfg_word = cfg_word_q;

endmodule

// File: rtl/cfgrb_checker.sv
module cfgrb_checker #(
   parameter int CFG_W = 12
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       arm,
   input logic                       conv_rise,
   input logic                       commit,
   input logic [CFG_W-1:0]           new_word,
   input logic [$clog2(CFG_W+1)-1:0] bit_cnt,
   input logic [CFG_W-1:0]           cfg_word,
   input logic                       dout
);

   // R3: stored word changes only on a completed write, to the assembled value
   assert_word_from_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word != $past(cfg_word)) |-> $past(commit));

   assert_word_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(commit) |-> (cfg_word == $past(new_word)));

   // R3 / R4: receiver never counts past the word length
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt < CFG_W);

   // R6: first frame bit is the stored word's MSB right after commit
   assert_first_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(commit) |-> (dout == cfg_word[CFG_W-1]));

   // R11: output quiet after the conversion strobe
   assert_conv_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(conv_rise) |-> (dout == 1'b0));

   // R12: arming strobe silences the output
   assert_arm_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arm) |-> (dout == 1'b0));

endmodule

bind cfg_readback_port cfgrb_checker #(
   .CFG_W (CFG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .arm       (arm),
   .conv_rise (conv_rise),
   .commit    (commit),
   .new_word  (new_word),
   .bit_cnt   (bit_cnt),
   .cfg_word  (cfg_word),
   .dout      (dout)
);

// File: tb/cfg_readback_port_bench.sv
module cfg_readback_port_bench;

   localparam int          STEP = 5;
   localparam logic [3:0]  REV  = 4'hA;
   localparam logic [55:0] P0   = 56'h30F066012480F6;
   localparam logic [71:0] P1   = 72'h30F066012480F69055;
   localparam int          NVEC = 4;
   // each entry: {expected frame length, word}
   localparam logic [21:0] VEC [NVEC] = '{
      {10'd640, 12'hA53}, {10'd512, 12'h3C4},
      {10'd640, 12'hFFF}, {10'd512, 12'h7E2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_rst_n = 1'b1;
   logic        conv = 1'b0;
   logic        cfg_sdi = 1'b0;
   logic        cfg_sclk = 1'b0;
   logic        dclk = 1'b0;
   logic        din = 1'b0;
   logic        dout;
   logic [11:0] cfg_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cfg_readback_port #(.REV_ID(REV)) u_cfg_readback_port (
      .clk(clk), .rst_n(rst_n), .cfg_rst_n(cfg_rst_n), .conv(conv),
      .cfg_sdi(cfg_sdi), .cfg_sclk(cfg_sclk), .dclk(dclk), .din(din),
      .dout(dout), .cfg_word(cfg_word)
   );

   task automatic wait_step();
      repeat (STEP) @(negedge clk);
   endtask

   task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      end
   endtask

   task automatic arm_pulse();
      cfg_rst_n = 1'b0; wait_step();
      cfg_rst_n = 1'b1; wait_step();
   endtask

   task automatic conv_strobe();
      conv = 1'b1; wait_step();
      conv = 1'b0; wait_step();
   endtask

   task automatic send_bits(input logic [11:0] w, input int n);
      for (int i = 11; i > 11 - n; i--) begin
         cfg_sdi = w[i]; cfg_sclk = 1'b1; wait_step();
         cfg_sclk = 1'b0; wait_step();
      end
   endtask

   task automatic dclk_pulse(input logic v);
      din = v; dclk = 1'b1; wait_step();
      dclk = 1'b0; wait_step();
   endtask

   function automatic logic fwd_pat(input int k);
      return logic'((k % 3) == 0);
   endfunction

   // expected frame bit k of a word's own frame
   function automatic logic exp_bit(input logic [11:0] w, input int k);
      int half, field, j, r;
      half  = w[0] ? 320 : 256;
      field = w[0] ? 304 : 240;
      j = k % half;
      if (j < 12) return w[11-j];
      if (j < 16) return REV[15-j];
      r = field - 1 - (j - 16);
      if (w[0]) return (r < 72) ? P1[r] : 1'b0;
      return (r < 56) ? P0[r] : 1'b0;
   endfunction

   function automatic string tag_of(input logic [11:0] w, input int k);
      int half, j;
      half = w[0] ? 320 : 256;
      j = k % half;
      if (k >= half) return "R9";
      if (j < 16) return "R6";
      return w[0] ? "R7" : "R8";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      logic [11:0] w;
      int          len;

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_step();
      check(cfg_word, 12'h000, "R1 word");
      check({11'd0, dout}, 12'd0, "R1 dout");

      // R2: strobe while conv high is ignored
      conv = 1'b1; wait_step();
      arm_pulse();
      send_bits(12'h5A5, 12);
      check(cfg_word, 12'h000, "R2 word");
      check({11'd0, dout}, 12'd0, "R2 dout");
      conv = 1'b0; wait_step();

      // vector table: full write, frame, chain forwarding, exit
      for (int v = 0; v < NVEC; v++) begin
         w   = VEC[v][11:0];
         len = int'(VEC[v][21:12]);
         arm_pulse();
         send_bits(w, 12);
         check(cfg_word, w, "R3");
         for (int k = 0; k < len + 8; k++) begin
            if (k < len) check({11'd0, dout}, {11'd0, exp_bit(w, k)}, tag_of(w, k));
            else         check({11'd0, dout}, {11'd0, fwd_pat(k - len)}, "R10");
            dclk_pulse(fwd_pat(k));
         end
         conv_strobe();
         check({11'd0, dout}, 12'd0, "R11 dout");
         dclk_pulse(1'b1);
         check({11'd0, dout}, 12'd0, "R11 dclk ignored");
         check(cfg_word, w, "R11 word kept");
      end

      // R4: partial write abandoned by conv
      arm_pulse();
      send_bits(12'h123, 7);
      conv_strobe();
      check(cfg_word, 12'h7E2, "R4 word");
      check({11'd0, dout}, 12'd0, "R4 dout");

      // R5: re-arm mid-write restarts the count
      arm_pulse();
      send_bits(12'hFFF, 5);
      arm_pulse();
      send_bits(12'h9C6, 12);
      check(cfg_word, 12'h9C6, "R5 word");
      check({11'd0, dout}, 12'd1, "R5 first bit");

      // R12: arm during readback aborts the frame
      for (int k = 0; k < 20; k++) dclk_pulse(1'b0);
      arm_pulse();
      check({11'd0, dout}, 12'd0, "R12 dout");
      check(cfg_word, 12'h9C6, "R12 word kept");
      send_bits(12'h246, 12);
      check(cfg_word, 12'h246, "R12 new word");
      for (int k = 0; k < 16; k++) begin
         check({11'd0, dout}, {11'd0, exp_bit(12'h246, k)}, "R12 frame");
         dclk_pulse(1'b0);
      end
      conv_strobe();
      check({11'd0, dout}, 12'd0, "R11 final");

      report();
      $finish;
   end

endmodule